// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block sits on the controller side of a single-data-rate SDRAM and issues the column-phase commands for a row that some other logic has already opened. A client presents one request at a time: bank, start column, direction, burst length and an auto-precharge wish. The block turns the request into a READ or WRITE on the command pins. It walks the column counter for every beat and drives the write data bus with its output enable. It also raises a capture strobe in the cycles where read data is valid on the memory side. CAS latency and burst length come in as inputs, because mode-register programming is done elsewhere.

Write data is taken from the client one beat ahead. The first beat goes out in the same cycle as the WRITE command, and each later beat goes out in the next cycle. A new request may land on any clock and cuts the running burst short. A separate terminate input ends a burst by issuing BURST TERMINATE. Read data then stops CL-1 cycles after that command. A burst that asked for auto precharge cannot be cut, and the block holds `ready` low until its last beat.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and just after it, chip select and RAS/CAS/WE are all high, `sd_dq_oe` and `rd_capture` are low, and `ready` is high.
- R2: An accepted request (`req_valid` and `ready` high at a clock edge) puts its command on the pins in the next cycle, with chip select low. READ is RAS/CAS/WE = 1,0,1 and WRITE is 1,0,0. `sd_ba` carries the bank and `sd_addr` the start column, and `sd_a10` is high only when auto precharge was asked for.
- R3: For a write, beat 0 (the `wr_data` given with the request) is on `sd_dq_out` with `sd_dq_oe` high in the command cycle. Beat i is the `wr_data` present on the clock edge where `wd_take` was high, and it appears i cycles after the command.
- R4: `burst_sel` 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. After the last beat of a fixed burst with nothing new, `sd_dq_oe` is low and the command pins are deselected (all high).
- R5: `burst_sel` 7 selects a full page, which runs until terminated. During beats `sd_addr` shows the current column, which counts up by one per cycle and wraps from 511 to 0.
- R6: A request accepted while a burst is running replaces it on the next cycle. The new command's column, bank and first data beat belong to the new access.
- R7: A request accepted in the last beat cycle of a fixed burst gives its command in the next cycle, so `sd_dq_oe` has no gap between two chained writes.
- R8: For CAS latency CL in 1..3, `rd_capture` is high exactly in the cycles that lie CL cycles after each read beat cycle, and low otherwise.
- R9: `term_req` high at an edge during a running burst with beats still to come puts BURST TERMINATE (RAS/CAS/WE = 1,1,0) on the pins in the next cycle. No beat belongs to that cycle, so the last read strobe falls CL-1 cycles after the terminate command and a write stops driving in it.
- R10: While an auto-precharge burst has beats left, `ready` is low, requests are not taken and `term_req` has no effect. Auto precharge is never flagged on A10 for a full-page burst.
- R11: `term_req` while idle, or on the last beat of a burst, leaves the pins deselected. A request given together with `term_req` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| burst_sel | input | 3 | Burst length code: 0..3 for 1/2/4/8 beats, 7 for full page |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 2 | Bank of the access |
| req_col | input | 9 | Start column |
| req_ap | input | 1 | Auto precharge after the burst |
| term_req | input | 1 | Ask to end the running burst |
| wr_data | input | 16 | Write beat from the client |
| ready | output | 1 | A request will be accepted at this edge |
| wd_take | output | 1 | `wr_data` is taken at this edge |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 9 | Column address, current column during beats |
| sd_a10 | output | 1 | Auto precharge flag |
| sd_dq_out | output | 16 | Write data to the bus |
| sd_dq_oe | output | 1 | Output enable for the data bus |
| rd_capture | output | 1 | Read data valid on the bus this cycle |

## Verification
The sweep runs reads and writes of every fixed length at two start columns: column 0, and column 509, where an eight-beat burst crosses the 511-to-0 wrap. Reads repeat at each CAS latency, so a wrong strobe delay or a wrong beat count shows up as a misplaced edge of `rd_capture`. Full-page bursts are cut by terminate after a few beats, which separates the wrap and the CL-1 stop rule from the fixed-length end. Directed sequences cover a write cut by a new write, two writes chained with no gap, and an auto-precharge read that must ignore both terminate and a new request. They also cover a terminate given while idle.

// File: rtl/sdram_seq_pkg.sv
// Package: shared opcode type and burst-length decode for the column sequencer.
// Assumes burst_sel codes 0..3 are fixed lengths and 7 is full page.
package sdram_seq_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_TERM  = 2'd3
    } seq_op_t;

    localparam logic [2:0] LEN_FULL = 3'd7;
    localparam int         LEFT_W   = 3;

    // Number of beats after the first one for a fixed-length code.
    function automatic logic [LEFT_W-1:0] beats_after_first(input logic [2:0] sel);
        case (sel)
            3'd1:    return 3'd1;
            3'd2:    return 3'd3;
            3'd3:    return 3'd7;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/seq_burst_ctr.sv
// Burst counter: holds the state of the beat on the bus this cycle
// (active, column, beats left, direction, auto precharge, full page).
// Assumes the parent raises stop_i only when more_o is high.
module seq_burst_ctr
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  ld_col_i,
    input  logic [LEFT_W-1:0] ld_left_i,
    input  logic              ld_full_i,
    input  logic              ld_wr_i,
    input  logic              ld_ap_i,
    output logic              act_o,
    output logic [COL_W-1:0]  col_o,
    output logic              wr_o,
    output logic              ap_o,
    output logic              more_o
);
    logic              act_q;
    logic [COL_W-1:0]  col_q;
    logic [LEFT_W-1:0] left_q;
    logic              full_q;
    logic              wr_q;
    logic              ap_q;

    // Another beat follows this one unless something intervenes.
    assign more_o = act_q && (full_q || (left_q != '0));

    // Load a new burst, stop it, step the column, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            col_q  <= '0;
            left_q <= '0;
            full_q <= 1'b0;
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
        end else if (load_i) begin
            act_q  <= 1'b1;
            col_q  <= ld_col_i;
            left_q <= ld_left_i;
            full_q <= ld_full_i;
            wr_q   <= ld_wr_i;
            ap_q   <= ld_ap_i;
        end else if (stop_i) begin
            act_q  <= 1'b0;
        end else if (more_o) begin
            col_q  <= col_q + 1'b1;
            if (!full_q) begin
                left_q <= left_q - 1'b1;
            end
        end else begin
            act_q  <= 1'b0;
        end
    end

    assign act_o = act_q;
    assign col_o = col_q;
    assign wr_o  = wr_q;
    assign ap_o  = ap_q;
endmodule

// File: rtl/seq_cmd_drive.sv
// Command pin driver: registers the opcode onto CS/RAS/CAS/WE, latches bank
// and A10 with each access command, and holds the write data beat.
// Assumes op_i is OP_NONE on cycles with no command.
module seq_cmd_drive
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_t           op_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              a10_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              a10_o,
    output logic [DATA_W-1:0] dq_o
);
    logic is_access;
    assign is_access = (op_i == OP_READ) || (op_i == OP_WRITE);

    // Encode the opcode onto the command pins for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
        end else begin
            case (op_i)
                OP_READ:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0101;
                OP_WRITE: {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0100;
                OP_TERM:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0110;
                default:  {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
            endcase
        end
    end

    // Bank follows access commands; A10 is set only in a flagged command cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ba_o  <= '0;
            a10_o <= 1'b0;
        end else begin
            if (is_access) begin
                ba_o <= bank_i;
            end
            a10_o <= is_access && a10_i;
        end
    end

    // Capture a write beat whenever the client data is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_o <= '0;
        end else if (take_i) begin
            dq_o <= wdata_i;
        end
    end
endmodule

// File: rtl/seq_rd_capture.sv
// Read strobe delay line: delays the read-beat flag by the CAS latency.
// Assumes a latency of 0 is treated as 1 and values above MAX_CL as MAX_CL.
module seq_rd_capture #(
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_i,
    input  logic [CL_W-1:0] cas_lat_i,
    output logic            cap_o
);
    logic [MAX_CL-1:0] stage_q;

    // Shift the read-beat flag one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= beat_i;
            for (int k = 1; k < MAX_CL; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    // Pick the tap matching the latency.
    always_comb begin
        if (cas_lat_i == '0) begin
            cap_o = stage_q[0];
        end else if (int'(cas_lat_i) > MAX_CL) begin
            cap_o = stage_q[MAX_CL-1];
        end else begin
            cap_o = stage_q[int'(cas_lat_i) - 1];
        end
    end

    // R8: with latency 1 the strobe is the beat flag one cycle late.
    p_cap_cl1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat_i == CL_W'(1)) |-> (cap_o == $past(beat_i)));
endmodule

// File: rtl/sdram_col_seq.sv
// Top: column-phase command sequencer for an opened SDRAM row. Accepts
// requests, walks bursts, drives write data and the read-capture strobe.
// Assumes the row is active and the client keeps reads and writes from
// colliding on the data bus.
module sdram_col_seq
    import sdram_seq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int DATA_W = 16,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [2:0]        burst_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic              term_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              wd_take,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [COL_W-1:0]  sd_addr,
    output logic              sd_a10,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic              rd_capture
);
    logic             act_w, wr_w, ap_w, more_w;
    logic             accept, term_ok, advance, full_sel, ap_eff;
    logic [COL_W-1:0] col_w;
    seq_op_t          op_nxt;

    // Decide what the next bus cycle carries.
    always_comb begin
        full_sel = (burst_sel == LEN_FULL);
        ap_eff   = req_ap && !full_sel;
        ready    = !(ap_w && more_w);
        accept   = req_valid && ready;
        term_ok  = term_req && !accept && more_w && !ap_w;
        advance  = !accept && !term_ok && more_w;
        wd_take  = (accept && req_write) || (advance && wr_w);
        if (accept) begin
            op_nxt = req_write ? OP_WRITE : OP_READ;
        end else if (term_ok) begin
            op_nxt = OP_TERM;
        end else begin
            op_nxt = OP_NONE;
        end
    end

    seq_burst_ctr #(.COL_W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .stop_i    (term_ok),
        .ld_col_i  (req_col),
        .ld_left_i (full_sel ? '0 : beats_after_first(burst_sel)),
        .ld_full_i (full_sel),
        .ld_wr_i   (req_write),
        .ld_ap_i   (ap_eff),
        .act_o     (act_w),
        .col_o     (col_w),
        .wr_o      (wr_w),
        .ap_o      (ap_w),
        .more_o    (more_w)
    );

    seq_cmd_drive #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_nxt),
        .bank_i  (req_bank),
        .a10_i   (ap_eff),
        .take_i  (wd_take),
        .wdata_i (wr_data),
        .cs_n_o  (sd_cs_n),
        .ras_n_o (sd_ras_n),
        .cas_n_o (sd_cas_n),
        .we_n_o  (sd_we_n),
        .ba_o    (sd_ba),
        .a10_o   (sd_a10),
        .dq_o    (sd_dq_out)
    );

    seq_rd_capture #(.MAX_CL(MAX_CL)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_i    (act_w && !wr_w),
        .cas_lat_i (cas_lat),
        .cap_o     (rd_capture)
    );

    assign sd_addr  = col_w;
    assign sd_dq_oe = act_w && wr_w;

    // R3: the bus is only ever turned on together with a WRITE command.
    p_oe_with_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_dq_oe) |-> (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n));

    // R10: a low ready keeps any access command off the next cycle.
    p_ready_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !(!sd_cs_n && !sd_cas_n));

    // R10: a terminate never follows an auto-precharge beat.
    p_term_not_ap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_cas_n && !sd_we_n) |-> !$past(ap_w));

    // R5: inside a burst the column steps by one, wrapping at the top.
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && $past(act_w) && sd_cs_n) |-> (col_w == COL_W'($past(col_w) + 1'b1)));
endmodule

// File: tb/sdram_col_seq_test.sv
`timescale 1ns/1ps
module sdram_col_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cas_lat;
    logic [2:0]  burst_sel;
    logic        req_valid, req_write, req_ap, term_req;
    logic [1:0]  req_bank;
    logic [8:0]  req_col;
    logic [15:0] wr_data;
    logic        ready, wd_take, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [8:0]  sd_addr;
    logic        sd_a10, sd_dq_oe, rd_capture;
    logic [15:0] sd_dq_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit exp_cap [0:1023];

    wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    localparam logic [3:0] C_RD = 4'b0101, C_WR = 4'b0100, C_BT = 4'b0110, C_DS = 4'b1111;

    sdram_col_seq uut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .burst_sel(burst_sel),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_col(req_col), .req_ap(req_ap), .term_req(term_req), .wr_data(wr_data),
        .ready(ready), .wd_take(wd_take), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_a10(sd_a10), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .rd_capture(rd_capture)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic logic [15:0] pat(input logic [8:0] c, input int i);
        logic [6:0] k = 7'(i);
        return {k, c};
    endfunction

    // R8: strobe checked every cycle against the schedule built from read beats.
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R8 rd_capture", rd_capture, exp_cap[cyc % 1024]);
            exp_cap[cyc % 1024] = 1'b0;
        end
    end

    task automatic mark_read();
        exp_cap[(cyc + int'(cas_lat)) % 1024] = 1'b1;
    endtask

    // One burst from request to drain; n beats, optional terminate after the last.
    task automatic run_burst(input bit wr, input logic [2:0] sel, input logic [8:0] col,
                             input logic [1:0] bk, input int n, input bit term);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; burst_sel = sel; req_col = col;
        req_bank = bk; req_ap = 1'b0; wr_data = pat(col, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0;
                chk("R2 command", cmd, wr ? C_WR : C_RD);
                chk("R2 bank", sd_ba, bk);
                chk("R2 a10", sd_a10, 0);
            end else begin
                chk("R4 no command mid-burst", cmd, C_DS);
            end
            chk("R5 column", sd_addr, 9'(col + 9'(i)));
            chk("R3 dq_oe", sd_dq_oe, wr);
            if (wr) chk("R3 write beat", sd_dq_out, pat(col, i));
            else mark_read();
            wr_data = pat(col, i + 1);
            if (term && i == n - 1) term_req = 1'b1;
        end
        @(negedge clk);
        term_req = 1'b0;
        chk(term ? "R9 terminate" : "R4 end of burst", cmd, term ? C_BT : C_DS);
        chk("R4 bus released", sd_dq_oe, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cas_lat = 2'd1; burst_sel = 3'd0; req_valid = 1'b0;
        req_write = 1'b0; req_ap = 1'b0; term_req = 1'b0; req_bank = '0;
        req_col = '0; wr_data = '0;
        for (int i = 0; i < 1024; i++) exp_cap[i] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset command", cmd, C_DS);
        chk("R1 reset dq_oe", sd_dq_oe, 0);
        chk("R1 reset capture", rd_capture, 0);
        chk("R1 reset ready", ready, 1);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // Sweep: fixed lengths, both directions, every latency for reads, two start columns.
        for (int w = 0; w < 2; w++)
            for (int cl = 1; cl <= 3; cl++) begin
                if (w == 1 && cl > 1) continue;
                cas_lat = 2'(cl);
                for (int s = 0; s < 4; s++)
                    for (int ci = 0; ci < 2; ci++)
                        run_burst(w[0], 3'(s), ci ? 9'd509 : 9'd0, 2'(s), 1 << s, 1'b0);
            end

        // Full page with wrap and terminate.
        for (int cl = 1; cl <= 3; cl++) begin
            cas_lat = 2'(cl);
            run_burst(1'b0, 3'd7, 9'd508, 2'(cl), 6, 1'b1);
        end
        cas_lat = 2'd1;
        run_burst(1'b1, 3'd7, 9'd510, 2'd1, 5, 1'b1);

        // R10: auto-precharge read ignores terminate and new requests until its last beat.
        cas_lat = 2'd2;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; burst_sel = 3'd2; req_col = 9'd20;
        req_bank = 2'd3; req_ap = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 read command", cmd, C_RD);
        chk("R2 a10 flagged", sd_a10, 1);
        chk("R10 ready low", ready, 0);
        mark_read(); term_req = 1'b1;
        @(negedge clk);
        chk("R10 terminate ignored", cmd, C_DS);
        chk("R10 ready low", ready, 0);
        mark_read();
        req_valid = 1'b1; req_write = 1'b1; req_ap = 1'b0; burst_sel = 3'd0; req_col = 9'd33;
        @(negedge clk);
        chk("R10 request blocked", cmd, C_DS);
        chk("R10 no write beat", sd_dq_oe, 0);
        chk("R10 burst continues", sd_addr, 22);
        mark_read(); req_valid = 1'b0;
        @(negedge clk);
        chk("R10 burst continues", cmd, C_DS);
        chk("R10 ready on last beat", ready, 1);
        mark_read();
        @(negedge clk);
        chk("R11 terminate on last beat ignored", cmd, C_DS);
        term_req = 1'b0;
        repeat (4) @(negedge clk);

        // R10: full page never flags A10 even if auto precharge was asked for.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; burst_sel = 3'd7; req_col = 9'd5; req_ap = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_ap = 1'b0;
        chk("R10 full page a10 low", sd_a10, 0);
        mark_read(); term_req = 1'b1;
        @(negedge clk);
        term_req = 1'b0;
        chk("R9 full page terminable", cmd, C_BT);
        repeat (5) @(negedge clk);

        // R11: terminate while idle does nothing.
        term_req = 1'b1;
        @(negedge clk);
        chk("R11 idle terminate", cmd, C_DS);
        term_req = 1'b0;
        @(negedge clk);

        // R6: an 8-beat write cut after two beats by a 2-beat write.
        cas_lat = 2'd1;
        req_valid = 1'b1; req_write = 1'b1; burst_sel = 3'd3; req_col = 9'd100;
        req_bank = 2'd1; wr_data = pat(9'd100, 0);
        @(negedge clk);
        req_valid = 1'b0; wr_data = pat(9'd100, 1);
        chk("R3 first beat", sd_dq_out, pat(9'd100, 0));
        @(negedge clk);
        chk("R3 second beat", sd_dq_out, pat(9'd100, 1));
        req_valid = 1'b1; burst_sel = 3'd1; req_col = 9'd300; req_bank = 2'd2;
        wr_data = pat(9'd300, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 new write command", cmd, C_WR);
        chk("R6 new column", sd_addr, 300);
        chk("R6 new bank", sd_ba, 2);
        chk("R6 new data", sd_dq_out, pat(9'd300, 0));
        wr_data = pat(9'd300, 1);
        @(negedge clk);
        chk("R6 new second beat", sd_dq_out, pat(9'd300, 1));
        chk("R6 new second column", sd_addr, 301);
        @(negedge clk);
        chk("R6 old burst gone", sd_dq_oe, 0);
        chk("R6 old burst gone", cmd, C_DS);
        repeat (3) @(negedge clk);

        // R7: a 2-beat write chained to a 1-beat write with no gap.
        req_valid = 1'b1; req_write = 1'b1; burst_sel = 3'd1; req_col = 9'd10;
        wr_data = pat(9'd10, 0);
        @(negedge clk);
        req_valid = 1'b0; wr_data = pat(9'd10, 1);
        chk("R7 first write", cmd, C_WR);
        @(negedge clk);
        chk("R7 last beat driven", sd_dq_oe, 1);
        req_valid = 1'b1; burst_sel = 3'd0; req_col = 9'd40; wr_data = pat(9'd40, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 chained command", cmd, C_WR);
        chk("R7 no gap", sd_dq_oe, 1);
        chk("R7 chained data", sd_dq_out, pat(9'd40, 0));
        @(negedge clk);
        chk("R4 single beat ends", sd_dq_oe, 0);
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule